// File: doc/BRIEF.md
# Bit-Elastic Store with Pointer-Distance Limit Alarm

This block is a one-bit-wide elastic store for a jitter-smoothing data path. Bits go in with a write enable and come out with a read enable. The pointer distance is the number of bits held between the write and read pointers. The block watches that distance in both directions. When the store nears empty it is close to underflow, and when it nears full it is close to overflow. In either case it raises a live near-limit alarm.

A read on an empty store or a write on a full store is an access error. The offending access is refused and a sticky error flag is set. Every change in the alarm, whether it rises or falls, latches an interrupt status bit. That bit is cleared by an acknowledge strobe, which stands for a clear-on-read access. An enable bit lets the latched status pull the active-low interrupt request.

A pointer-reset strobe, which stands for the control bit a processor writes, puts the pointers back at half depth and clears the error flag. Both clocks are modelled as one clock with separate write and read enables.

Top module: `bit_elastic_limit_mon`

## Requirements
- R1: After reset the store holds DEPTH/2 bits, `alarm_status` and `int_status` read 0, `rd_data` is 0 and `irq_n` is 1.
- R2: Bits that are accepted come out of `rd_data` in the order they were written. An accepted read updates `rd_data` on the clock edge that takes it; otherwise `rd_data` holds.
- R3: Bit 3 of `alarm_status` reads 1 exactly when the held count is at most LIMIT (default 2) or at least DEPTH-LIMIT. It follows the count with no added delay.
- R4: A read while the store is empty is refused: the pointers and `rd_data` hold. It sets bit 0 of `alarm_status`, and that bit stays set until a pointer reset.
- R5: A write while the store holds DEPTH bits, with no read in the same cycle, is refused and sets bit 0 of `alarm_status`. A write and a read together on a full store are both accepted.
- R6: Every change of alarm bit 3, whether it rises or falls, sets bit 3 of `int_status` one clock after the change. This happens whatever the value of `irq_en`.
- R7: A pulse on `int_ack` clears bit 3 of `int_status` on the next edge. If a new alarm change is latched in that same cycle, the bit stays set.
- R8: `irq_n` is 0 exactly when bit 3 of `int_status` is 1 and `irq_en` is 1.
- R9: A pulse on `ptr_rst` restores a count of DEPTH/2 and clears bit 0 of `alarm_status`. Any write or read in that cycle is ignored. The interrupt logic keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides of the store |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one bit this cycle |
| wr_data | input | 1 | Bit to write |
| rd_en | input | 1 | Read one bit this cycle |
| rd_data | output | 1 | Last bit read |
| ptr_rst | input | 1 | Pointer-reset strobe |
| irq_en | input | 1 | Lets the latched status drive `irq_n` |
| int_ack | input | 1 | Clear-on-read strobe for the interrupt status |
| alarm_status | output | 8 | Bit 3 is the live near-limit alarm, bit 0 is the sticky access error, the other bits are 0 |
| int_status | output | 8 | Bit 3 is the latched alarm-change flag, the other bits are 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench drains the store from half depth down past empty, and later fills it up past full. This tests the alarm edges at counts 2, 3, DEPTH-3 and DEPTH-2. An off-by-one threshold would move the alarm one bit early or late. Using pointers without the extra wrap bit would confuse empty with full, so the store would raise no error or would read stale bits.

The bench also checks that the falling edge of the alarm latches the interrupt, and that a pointer reset which clears the alarm does so too. A design that latched only declarations would leave `int_status` at 0 there.

It applies an acknowledge in the same cycle as a new change. It also runs a long random stretch with `irq_en` off. A clear that beat the set, or an enable that gated the latch, would show up as a mismatch against the bench's arithmetic model.

// File: rtl/bef_pkg.sv
// Package: shared constants for the bit-elastic limit monitor.
// Assumes: status bytes are 8 bits wide; bit positions are fixed for the register decoder.
package bef_pkg;
    localparam int STAT_W   = 8;
    localparam int ALARM_BIT = 3;   // near-limit alarm / change flag position
    localparam int ERR_BIT   = 0;   // sticky access error position
endpackage

// File: rtl/bef_ptr.sv
// Module: bef_ptr
// Keeps the write and read pointers, with one extra wrap bit, and derives the held count.
// Refuses a read when the store is empty and a write when it is full with no read.
// Keeps a sticky error flag until a pointer reset.
// Assumes: DEPTH is a power of two; ptr_rst takes priority over both accesses.
module bef_ptr #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ptr_rst,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ,
    output logic          err
);
    localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_C = (AW+1)'(DEPTH / 2);

    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    logic        under;
    logic        over;

    // Work out the held count and which accesses are accepted this cycle.
    always_comb begin
        occ   = wr_ptr - rd_ptr;
        under = rd_en && (occ == '0);
        over  = wr_en && (occ == FULL_C) && !rd_en;
        rd_go = rd_en && !under && !ptr_rst;
        wr_go = wr_en && !over && !ptr_rst;
    end

    assign wr_addr = wr_ptr[AW-1:0];
    assign rd_addr = rd_ptr[AW-1:0];

    // Advance the pointers, recentre them on a pointer reset, and hold the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_rst) begin
            wr_ptr <= HALF_C;
            rd_ptr <= '0;
            err    <= 1'b0;
        end else begin
            if (wr_go) wr_ptr <= wr_ptr + 1'b1;
            if (rd_go) rd_ptr <= rd_ptr + 1'b1;
            if (under || over) err <= 1'b1;
        end
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ptr_rst && occ == '0) |=> ($stable(rd_ptr) && err));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !ptr_rst && occ == FULL_C) |=> ($stable(wr_ptr) && err));
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ptr_rst) |=> err);
    // R9
    ptr_recentre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (occ == HALF_C && !err));
    // R5
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_C);
endmodule

// File: rtl/bef_store.sv
// Module: bef_store
// The one-bit-wide storage array with a registered read output.
// Assumes: the pointer logic already refuses illegal accesses. A write and a read to the
// same cell on a full store return the old bit, which is the oldest one held.
module bef_store #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);
    logic [DEPTH-1:0] cells;

    // Write accepted bits into the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (wr_go) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Capture the addressed bit on an accepted read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 1'b0;
        end else if (rd_go) begin
            rd_data <= cells[rd_addr];
        end
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/bef_limit.sv
// Module: bef_limit
// Compares the held count against the near-limit window in both directions.
// Latches an interrupt flag on any change of the alarm and gates the request pin.
// Assumes: int_ack is a one-cycle clear strobe, and a new change outranks the clear.
module bef_limit #(
    parameter int DEPTH = 32,
    parameter int LIMIT = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] occ,
    input  logic        irq_en,
    input  logic        int_ack,
    output logic        alarm,
    output logic        int_flag,
    output logic        irq_n
);
    localparam logic [AW:0] LO_C = (AW+1)'(LIMIT);
    localparam logic [AW:0] HI_C = (AW+1)'(DEPTH - LIMIT);

    logic alarm_d;

    // Live alarm: near empty or near full.
    assign alarm = (occ <= LO_C) || (occ >= HI_C);

    // Remember the alarm and latch the change flag; a change beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_d  <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            alarm_d <= alarm;
            if (alarm != alarm_d) int_flag <= 1'b1;
            else if (int_ack)     int_flag <= 1'b0;
        end
    end

    // Drive the request pin low while an enabled flag is pending.
    assign irq_n = !(int_flag && irq_en);

    // R6
    alarm_rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |=> int_flag);
    // R6
    alarm_fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |=> int_flag);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && $stable(alarm)) |=> !int_flag);
    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (int_flag && irq_en));
endmodule

// File: rtl/bit_elastic_limit_mon.sv
// Module: bit_elastic_limit_mon (top)
// A one-bit elastic store with a two-sided pointer-distance alarm, a sticky access error,
// a latched change interrupt and an active-low request.
// Assumes: both clock domains are modelled as one clock with separate enables.
module bit_elastic_limit_mon #(
    parameter int DEPTH = 32,
    parameter int LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_data,
    input  logic       rd_en,
    output logic       rd_data,
    input  logic       ptr_rst,
    input  logic       irq_en,
    input  logic       int_ack,
    output logic [7:0] alarm_status,
    output logic [7:0] int_status,
    output logic       irq_n
);
    import bef_pkg::*;
    localparam int AW = $clog2(DEPTH);

    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW:0]   occ;
    logic          err;
    logic          alarm;
    logic          int_flag;

    bef_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ptr_rst(ptr_rst),
        .wr_go(wr_go), .rd_go(rd_go), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .occ(occ), .err(err)
    );

    bef_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    bef_limit #(.DEPTH(DEPTH), .LIMIT(LIMIT), .AW(AW)) u_limit (
        .clk(clk), .rst_n(rst_n), .occ(occ), .irq_en(irq_en), .int_ack(int_ack),
        .alarm(alarm), .int_flag(int_flag), .irq_n(irq_n)
    );

    // Place the live bits at their register positions.
    always_comb begin
        alarm_status            = '0;
        alarm_status[ALARM_BIT] = alarm;
        alarm_status[ERR_BIT]   = err;
        int_status              = '0;
        int_status[ALARM_BIT]   = int_flag;
    end
endmodule

// File: tb/bit_elastic_limit_mon_bench.sv
module bit_elastic_limit_mon_bench;
    localparam int DEPTH = 32;
    localparam int LIMIT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_data = 1'b0, rd_en = 1'b0;
    logic       ptr_rst = 1'b0, irq_en = 1'b0, int_ack = 1'b0;
    logic       rd_data, irq_n;
    logic [7:0] alarm_status, int_status;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // arithmetic model
    int m_occ, m_wp, m_rp;
    bit m_mem [DEPTH];
    bit m_err, m_ad, m_int, m_rdb;

    always #2.5 clk = ~clk;

    bit_elastic_limit_mon #(.DEPTH(DEPTH), .LIMIT(LIMIT)) u_bit_elastic_limit_mon (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .ptr_rst(ptr_rst), .irq_en(irq_en), .int_ack(int_ack),
        .alarm_status(alarm_status), .int_status(int_status), .irq_n(irq_n)
    );

    function automatic bit m_alarm();
        return (m_occ <= LIMIT) || (m_occ >= DEPTH - LIMIT);
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one vector: compare every output against the model
    task automatic check_all();
        vectors++;
        cmp("R2 rd_data", rd_data, m_rdb);
        cmp("R3 alarm bit3", alarm_status[3], m_alarm());
        cmp("R4 R5 error bit0", alarm_status[0], m_err);
        cmp("R3 unused alarm bits", {alarm_status[7:4], alarm_status[2:1]}, 0);
        cmp("R6 R7 int bit3", int_status[3], m_int);
        cmp("R6 unused int bits", {int_status[7:4], int_status[2:0]}, 0);
        cmp("R8 irq_n", irq_n, !(m_int && irq_en));
    endtask

    task automatic model_reset();
        m_occ = DEPTH / 2; m_wp = DEPTH / 2; m_rp = 0;
        m_err = 0; m_ad = 0; m_int = 0; m_rdb = 0;
        foreach (m_mem[i]) m_mem[i] = 0;
    endtask

    // apply one cycle of inputs at the negedge, update the model at the edge, compare at the next negedge
    task automatic cyc(input bit w, input bit wb, input bit r, input bit ack, input bit pr, input bit en);
        bit a_now, rd_ok, wr_ok;
        wr_en = w; wr_data = wb; rd_en = r; int_ack = ack; ptr_rst = pr; irq_en = en;
        @(posedge clk);
        a_now = m_alarm();
        if (a_now != m_ad) m_int = 1;
        else if (ack)      m_int = 0;
        m_ad = a_now;
        if (pr) begin
            m_occ = DEPTH / 2; m_wp = DEPTH / 2; m_rp = 0; m_err = 0;
        end else begin
            rd_ok = r && (m_occ != 0);
            wr_ok = w && !(m_occ == DEPTH && !r);
            if ((r && m_occ == 0) || (w && m_occ == DEPTH && !r)) m_err = 1;
            if (rd_ok) begin m_rdb = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
            if (wr_ok) begin m_mem[m_wp] = wb; m_wp = (m_wp + 1) % DEPTH; end
            m_occ = m_occ + int'(wr_ok) - int'(rd_ok);
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all();
        cmp("R1 irq_n after reset", irq_n, 1);
        cmp("R1 alarm after reset", alarm_status, 0);

        // R2: steady stream at half depth, read and write together
        for (int i = 0; i < 48; i++) cyc(1, (i * 7 + 3) % 5 < 2, 1, 0, 0, 1);

        // R3, R4, R6: drain past empty; alarm rises at 2, error at underflow
        for (int i = 0; i < DEPTH / 2 + 3; i++) cyc(0, 0, 1, 0, 0, 1);
        // R7: acknowledge clears the flag
        cyc(0, 0, 0, 1, 0, 1);
        cmp("R7 flag cleared by ack", int_status[3], 0);
        cmp("R4 error held", alarm_status[0], 1);

        // R9: pointer reset ignores concurrent accesses, alarm falls, R6 latches the fall
        cyc(1, 1, 1, 0, 1, 1);
        cmp("R9 error cleared", alarm_status[0], 0);
        cmp("R9 alarm off at half depth", alarm_status[3], 0);
        cyc(0, 0, 0, 0, 0, 1);
        cmp("R6 fall latched", int_status[3], 1);

        // R8: mask on, fill past full; R5 overflow
        cyc(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < DEPTH / 2 + 3; i++) cyc(1, i[0] ^ i[2], 0, 0, 0, 0);
        cmp("R8 masked request", irq_n, 1);
        cmp("R6 latch while masked", int_status[3], 1);
        cyc(0, 0, 0, 0, 0, 1);
        cmp("R8 request after enable", irq_n, 0);
        // R5: write and read together on a full store
        cyc(1, 1, 1, 0, 0, 1);
        // R2: drain the filled store and check order
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 1, i[1], 0, 1);

        // near-exhaustive sweep: every count, mixed strobes
        cyc(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 6000; i++) begin
            int k = $urandom % 100;
            cyc(k < 55, $urandom % 2, (k % 3) != 0 && k > 10,
                ($urandom % 6) == 0, ($urandom % 400) == 0, ($urandom % 4) != 0);
        end
        // R7: acknowledge in the same cycle as a change keeps the flag
        cyc(0, 0, 0, 0, 1, 1);
        while (m_occ > LIMIT + 1) cyc(0, 0, 1, 1, 0, 1);
        cyc(0, 0, 1, 1, 0, 1);
        cyc(0, 0, 0, 1, 0, 1);
        cmp("R7 change outranks ack", int_status[3], 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule